// File: doc/BRIEF.md
# Adaptive-Rate Digital Regulator Switch Controller

This block is the digital control loop of a switched-transistor voltage regulator. A bank of identical power switches sits in parallel between the input rail and a core's supply. The controller decides how many of them conduct. On every sample tick it reads one comparator bit that says whether the regulated output is below or above its reference. It then moves the number of conducting switches up or down by one. The switch gates are driven from a thermometer-coded enable bus.

Sample ticks come from a divider of the system clock that has two run-time ratios, a slow one and a fast one. Two more comparator bits flag a large droop and a large overshoot. While either flag is up, the divider runs at the fast ratio. After both flags clear, the fast ratio stays in force for a programmable number of extra ticks and then falls back to the slow ratio. This trades response time against power and output ripple. A bypass input turns every switch on, so that the core connects straight to the rail, and it suspends regulation.

All three comparator bits are asynchronous to the clock. Each one passes through a two-flop synchronizer before the control logic uses it.

Top module: `dldo_reg_ctrl`

## Requirements
- R1: While `rstN` is low, `swEn` shows exactly `initCount` low bits on (clamped to `NUM_SW`) and `fastMode` is 0. After reset the block starts at the slow rate.
- R2: In steady state the switch count can change only once every `slowDiv` clock cycles while `fastMode` is 0, and once every `fastDiv` cycles while it is 1. A ratio of 0 behaves as 1.
- R3: On a tick with `cmpLowIn` = 1 (meaning the output is below the reference) and bypass off, the count rises by exactly one.
- R4: On a tick with `cmpLowIn` = 0 (meaning the output is above the reference) and bypass off, the count falls by exactly one.
- R5: The count saturates. It stays at `NUM_SW` under continued raise requests and stays at 0 under continued lower requests.
- R6: `swEn` is a thermometer code: bit i is 1 exactly when i is less than the count, so the low bits turn on first.
- R7: If `droopIn` or `overIn` rises, `fastMode` rises on the third rising clock edge after the change (two synchronizer stages plus one state register), and not before.
- R8: Counting from the first clock edge at which the cleared detectors have passed the synchronizer, `fastMode` stays 1 for exactly `holdTicks`+1 fast ticks. It falls on the edge of the last of those ticks, and that tick still moves the count. If a detector reasserts during this hold, the hold starts again.
- R9: While `bypassEn` is 1, all `swEn` bits are 1 in the same cycle, combinationally. The count is frozen during bypass. When bypass is released, `swEn` returns to the thermometer code of the frozen count, and regulation resumes.
- R10: Between sample ticks the enable bus holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpLowIn | input | 1 | Main comparator, asynchronous; 1 = output below reference |
| droopIn | input | 1 | Large-droop detector, asynchronous, 1 = active |
| overIn | input | 1 | Large-overshoot detector, asynchronous, 1 = active |
| bypassEn | input | 1 | 1 = all switches on, regulation suspended |
| slowDiv | input | DIV_W | Clock cycles per tick at the slow rate |
| fastDiv | input | DIV_W | Clock cycles per tick at the fast rate |
| holdTicks | input | HOLD_W | Extra fast ticks kept after the excursion clears |
| initCount | input | CNT_W | Switch count loaded during reset |
| swEn | output | NUM_SW | Thermometer-coded switch gate enables |
| fastMode | output | 1 | 1 while the fast sampling rate is in force |

## Verification
Three functions can land on one clock edge. The first is a regulation step. The second is a rate change: the end of the fast hold happens on a fast tick that must still move the count. The third is bypass entry or release, which must freeze or restore the count no matter where a tick falls. The bench holds the comparator steady so that every tick shows up as a one-switch step. It then counts steps between the synchronized clearing of the detectors and the fall of `fastMode`, and it compares the count across a bypass window during which ticks keep firing.

// File: rtl/dldo_pkg.sv
package dldo_pkg;
  // Step requests sent from the control to the switch datapath.
  typedef struct packed {
    logic inc;
    logic dec;
  } stepStrobe_t;
endpackage

// File: rtl/dldo_sync.sv
module dldo_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/dldo_rate_ctrl.sv
module dldo_rate_ctrl
  import dldo_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpLow,
  input  logic              excursion,
  input  logic              bypass,
  input  logic [DIV_W-1:0]  slowDiv,
  input  logic [DIV_W-1:0]  fastDiv,
  input  logic [HOLD_W-1:0] holdTicks,
  output stepStrobe_t       strobe,
  output logic              tick,
  output logic              fastQ
);
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  limit;
  logic [HOLD_W-1:0] holdCnt;

  function automatic logic [DIV_W-1:0] lastCount(input logic [DIV_W-1:0] ratio);
    return (ratio == '0) ? '0 : ratio - DIV_W'(1);
  endfunction

  assign limit = fastQ ? lastCount(fastDiv) : lastCount(slowDiv);
  // ">=" makes a ratio drop take effect at once.
  assign tick  = (divCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastQ   <= 1'b0;
      holdCnt <= '0;
    end else if (excursion) begin
      fastQ   <= 1'b1;
      holdCnt <= holdTicks;
    end else if (fastQ && tick) begin
      if (holdCnt == '0) begin
        fastQ <= 1'b0;
      end else begin
        holdCnt <= holdCnt - HOLD_W'(1);
      end
    end
  end

  assign strobe.inc = tick && !bypass && cmpLow;
  assign strobe.dec = tick && !bypass && !cmpLow;
endmodule

// File: rtl/dldo_switch_dp.sv
module dldo_switch_dp
  import dldo_pkg::*;
#(
  parameter int NUM_SW = 64,
  parameter int CNT_W  = $clog2(NUM_SW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobe_t       strobe,
  input  logic              bypass,
  input  logic [CNT_W-1:0]  initCount,
  output logic [NUM_SW-1:0] swEn
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SW);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= (initCount > FULL) ? FULL : initCount;
    end else if (strobe.inc && (count != FULL)) begin
      count <= count + CNT_W'(1);
    end else if (strobe.dec && (count != '0)) begin
      count <= count - CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_SW; i++) begin : g_therm
    assign swEn[i] = bypass || (count > CNT_W'(i));
  end
endmodule

// File: rtl/dldo_reg_ctrl.sv
module dldo_reg_ctrl
  import dldo_pkg::*;
#(
  parameter int NUM_SW = 64,
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 8,
  localparam int CNT_W = $clog2(NUM_SW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpLowIn,
  input  logic              droopIn,
  input  logic              overIn,
  input  logic              bypassEn,
  input  logic [DIV_W-1:0]  slowDiv,
  input  logic [DIV_W-1:0]  fastDiv,
  input  logic [HOLD_W-1:0] holdTicks,
  input  logic [CNT_W-1:0]  initCount,
  output logic [NUM_SW-1:0] swEn,
  output logic              fastMode
);
  logic        cmpLowS;
  logic        droopS;
  logic        overS;
  logic        sampleTick;
  stepStrobe_t strobe;

  dldo_sync #(.W(3)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({cmpLowIn, droopIn, overIn}),
    .syncOut ({cmpLowS, droopS, overS})
  );

  dldo_rate_ctrl #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmpLow    (cmpLowS),
    .excursion (droopS || overS),
    .bypass    (bypassEn),
    .slowDiv   (slowDiv),
    .fastDiv   (fastDiv),
    .holdTicks (holdTicks),
    .strobe    (strobe),
    .tick      (sampleTick),
    .fastQ     (fastMode)
  );

  dldo_switch_dp #(.NUM_SW(NUM_SW), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bypass    (bypassEn),
    .initCount (initCount),
    .swEn      (swEn)
  );
endmodule

// File: rtl/dldo_reg_ctrl_chk.sv
module dldo_reg_ctrl_chk #(
  parameter int NUM_SW = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              bypassEn,
  input logic [NUM_SW-1:0] swEn,
  input logic              fastMode,
  input logic              droopS,
  input logic              overS,
  input logic              sampleTick
);
  // R6: the enable bus is always a thermometer code
  assert_thermo_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((swEn & (swEn + 1'b1)) == '0));

  // R9: bypass turns on every switch
  assert_bypass_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    bypassEn |-> (&swEn));

  // R3 and R4: outside bypass, one step at most per cycle
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassEn && !$past(bypassEn)) |->
      (($countones(swEn) <= $countones($past(swEn)) + 1) &&
       ($countones($past(swEn)) <= $countones(swEn) + 1)));

  // R10: no tick means no change on the next edge
  assert_quiet_between_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && !bypassEn) |=> (bypassEn || $stable(swEn)));

  // R7: a synchronized excursion forces the fast rate
  assert_fast_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (droopS || overS) |=> fastMode);

  // R8: fast rate ends only on a tick with no excursion
  assert_fast_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fastMode) |-> ($past(sampleTick) && !$past(droopS || overS)));
endmodule

bind dldo_reg_ctrl dldo_reg_ctrl_chk #(.NUM_SW(NUM_SW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bypassEn   (bypassEn),
  .swEn       (swEn),
  .fastMode   (fastMode),
  .droopS     (droopS),
  .overS      (overS),
  .sampleTick (sampleTick)
);

// File: tb/sim_dldo_reg_ctrl.sv
`timescale 1ns/1ps
module sim_dldo_reg_ctrl;
  localparam int NSW = 64;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           cmpLowIn = 1'b0;
  logic           droopIn = 1'b0;
  logic           overIn = 1'b0;
  logic           bypassEn = 1'b0;
  logic [7:0]     slowDiv = 8'd4;
  logic [7:0]     fastDiv = 8'd2;
  logic [7:0]     holdTicks = 8'd3;
  logic [6:0]     initCount = 7'd10;
  logic [NSW-1:0] swEn;
  logic           fastMode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dldo_reg_ctrl u0 (
    .clk(clk), .rstN(rstN), .cmpLowIn(cmpLowIn), .droopIn(droopIn),
    .overIn(overIn), .bypassEn(bypassEn), .slowDiv(slowDiv),
    .fastDiv(fastDiv), .holdTicks(holdTicks), .initCount(initCount),
    .swEn(swEn), .fastMode(fastMode)
  );

  function automatic int cnt();
    return $countones(swEn);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Waits for a step, then times the next one; dir is the signed size of that step.
  task automatic measureGap(output int gap, output int dir);
    int c0;
    int guard;
    @(negedge clk);
    c0 = cnt();
    guard = 0;
    while (cnt() == c0 && guard < 600) begin @(negedge clk); guard++; end
    c0 = cnt();
    gap = 0;
    do begin @(negedge clk); gap++; end while (cnt() == c0 && gap < 600);
    dir = cnt() - c0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    settle(4);
    check("R1 reset enables", swEn, (64'd1 << 10) - 64'd1);
    check("R6 reset thermometer", cnt(), 10);
    check("R1 reset rate", fastMode, 0);
    @(posedge clk); #1 rstN = 1'b1;
    settle(1);
    check("R1 slow after reset", fastMode, 0);
  endtask

  task automatic testSlowSteps();
    int gap;
    int dir;
    cmpLowIn = 1'b1;
    measureGap(gap, dir);
    measureGap(gap, dir);
    check("R2 R10 slow gap rising", gap, 4);
    check("R3 raise step", dir, 1);
    cmpLowIn = 1'b0;
    measureGap(gap, dir);
    measureGap(gap, dir);
    check("R2 R10 slow gap falling", gap, 4);
    check("R4 lower step", dir, -1);
  endtask

  task automatic testSaturate();
    slowDiv = 8'd1;
    cmpLowIn = 1'b1;
    settle(90);
    check("R5 top reached", cnt(), NSW);
    settle(10);
    check("R5 top held", cnt(), NSW);
    cmpLowIn = 1'b0;
    settle(90);
    check("R5 bottom reached", cnt(), 0);
    settle(10);
    check("R5 bottom held", cnt(), 0);
    check("R6 empty bus", swEn, 0);
    slowDiv = 8'd4;
    cmpLowIn = 1'b1;
    settle(80);
  endtask

  task automatic testDroopFast();
    int gap;
    int dir;
    int c0;
    int guard;
    @(posedge clk); #1 droopIn = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 not early", fastMode, 0);
    @(posedge clk); @(negedge clk);
    check("R7 droop entry on third edge", fastMode, 1);
    measureGap(gap, dir);
    measureGap(gap, dir);
    check("R2 fast gap", gap, 2);
    @(posedge clk); #1 droopIn = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    c0 = cnt();
    guard = 0;
    while (fastMode && guard < 300) begin @(negedge clk); guard++; end
    check("R8 fast ticks in hold", cnt() - c0, 4);
    measureGap(gap, dir);
    measureGap(gap, dir);
    check("R8 back to slow gap", gap, 4);
  endtask

  task automatic testOverRestart();
    int c0;
    int guard;
    int lowest;
    cmpLowIn = 1'b0;
    @(posedge clk); #1 overIn = 1'b1;
    settle(4);
    check("R7 overshoot entry", fastMode, 1);
    @(posedge clk); #1 overIn = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    c0 = cnt();
    guard = 0;
    while (cnt() > c0 - 2 && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk); #1 droopIn = 1'b1;
    lowest = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!fastMode) lowest = 0;
    end
    check("R8 hold restarts on reassert", lowest, 1);
    @(posedge clk); #1 droopIn = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    c0 = cnt();
    guard = 0;
    while (fastMode && guard < 300) begin @(negedge clk); guard++; end
    check("R8 fresh hold length", c0 - cnt(), 4);
  endtask

  task automatic testBypass();
    int c0;
    int gap;
    int dir;
    cmpLowIn = 1'b0;
    settle(3);
    @(posedge clk); #1;
    c0 = cnt();
    bypassEn = 1'b1;
    #0.5;
    check("R9 all on at once", swEn, {NSW{1'b1}});
    settle(20);
    check("R9 all on held", cnt(), NSW);
    @(posedge clk); #1 bypassEn = 1'b0;
    @(negedge clk);
    check("R9 count frozen", cnt(), c0);
    measureGap(gap, dir);
    check("R9 regulation resumes", dir, -1);
  endtask

  initial begin
    testReset();
    testSlowSteps();
    testSaturate();
    testDroopFast();
    testOverRestart();
    testBypass();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule